// File: doc/BRIEF.md
# Ping-Pong Serial Shift-Out Port

This block turns 16-bit words into a single serial bit stream. Each new bit is presented on a data pin at a rate set by two cascaded clock dividers. The bit period, counted in core clock cycles, is the product of the two divider values. A serial clock output rises together with each new bit.

Two shadow buffers take turns as the data source. Each buffer has its own load strobe, so software can refill one buffer while the other is being sent. When a buffer is taken for sending, its contents are copied into a separate working shift register. The buffer is then free to be reloaded for the whole time its word is on the line.

The port has two modes. In free-running mode, it keeps sending words until enable is cleared, and it always completes the buffer in progress before it stops. In fixed-count mode, it sends a configured number of bits and then holds until enable is released. An underrun pulse marks the case where a buffer is taken without having been reloaded.

Top module: `pp_shift_tx`

## Requirements
- R1: After reset, `sdo`, `sclk`, `busy` and `underrun` are 0 and `free_buf` is 1.
- R2: One bit period lasts E(a)·E(b) core cycles. Here E(x) is 1 when x is 0 or 1 and x otherwise. The values a and b are `cfg_div_a` and `cfg_div_b`, taken at the cycle a run starts.
- R3: A run starts when `ctl_en` is seen high while the port is idle. Bit 0 of the word appears on `sdo` in the next cycle. Words go out least-significant bit first. Bit k is held on `sdo` for P cycles, starting P·k cycles after the first bit.
- R4: While `busy` is high, `sclk` is 1 during the first ceil(P/2) cycles of each bit period and 0 for the rest of the period. While the port is idle, `sclk` is 0.
- R5: `ctl_ld0` copies `ctl_data` into buffer 0 and `ctl_ld1` copies it into buffer 1. Loading a buffer whose word is currently being sent does not change the bits on `sdo`.
- R6: A run begins with buffer 0. After the last bit of a buffer, the next bit is bit 0 of the other buffer. While a run is in progress, `free_buf` gives the index of the buffer that is not being sent. When idle, `free_buf` is 1.
- R7: A buffer may be taken before it has been loaded again since its previous take. In that case, `underrun` is 1 for exactly the cycle in which that buffer's first bit appears, and the stale word is sent.
- R8: In free-running mode (`cfg_fixed`=0), `ctl_en` is examined only at the end of each buffer's last bit. If it is low at that point, the port stops: `busy` and `sdo` go to 0 in the next cycle. A low level of `ctl_en` between these points has no effect.
- R9: In fixed-count mode (`cfg_fixed`=1), exactly `cfg_nbits` bits are sent, and words continue across the buffer swap. Clearing `ctl_en` during the run has no effect. After the last bit the port stays stopped until `ctl_en` goes low. A count of 0 sends nothing.
- R10: Every run, whatever buffer the previous run ended in, starts with buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ctl_data | input | 16 | word to copy into a buffer |
| ctl_ld0 | input | 1 | load strobe for buffer 0 |
| ctl_ld1 | input | 1 | load strobe for buffer 1 |
| ctl_en | input | 1 | shift enable |
| cfg_fixed | input | 1 | 1 selects fixed-count mode, 0 selects free-running mode |
| cfg_div_a | input | 4 | first divider value |
| cfg_div_b | input | 4 | second divider value |
| cfg_nbits | input | 8 | number of bits to send in fixed-count mode |
| sdo | output | 1 | serial data |
| sclk | output | 1 | serial clock |
| busy | output | 1 | a run is in progress |
| free_buf | output | 1 | index of the buffer that may be reloaded |
| underrun | output | 1 | a stale buffer was taken |

## Verification
The assertions assume that the configuration inputs do not change while a run is in progress. They also assume that a load strobe never fires in the same cycle as the take of the buffer it targets. Under these conditions, data only moves on divider ticks, and a stop only ever follows a tick. The stimulus changes the configuration only while the port is idle. It places every reload a few cycles after a take, well away from any buffer boundary. The sweep covers every divider pair from 0 to 3, which includes the values 0 and 1 that both mean divide-by-1.

// File: rtl/pp_shift_pkg.sv
package pp_shift_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_st_e;

  // a divider setting of 0 or 1 both divide by one
  function automatic int unsigned div_eff(input int unsigned v);
    return (v < 2) ? 1 : v;
  endfunction

  // core cycles per serial bit
  function automatic int unsigned bit_period(input int unsigned a, input int unsigned b);
    return div_eff(a) * div_eff(b);
  endfunction

  // serial clock is high for the first half (rounded up) of each bit
  function automatic logic sclk_level(input int unsigned phase, input int unsigned a,
                                      input int unsigned b);
    return phase < ((bit_period(a, b) + 1) / 2);
  endfunction

endpackage

// File: rtl/pp_div2.sv
module pp_div2 #(
  parameter int DIV_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [DIV_W-1:0]   div_a,
  input  logic [DIV_W-1:0]   div_b,
  output logic               tick,
  output logic [2*DIV_W-1:0] phase
);
  localparam int PH_W = 2 * DIV_W;

  logic [DIV_W-1:0] cnt_a;
  logic [DIV_W-1:0] cnt_b;
  logic             wrap_a;
  logic             wrap_b;

  assign wrap_a = (cnt_a == div_a - DIV_W'(1));
  assign wrap_b = (cnt_b == div_b - DIV_W'(1));
  assign tick   = run && wrap_a && wrap_b;
  assign phase  = PH_W'(cnt_b) * PH_W'(div_a) + PH_W'(cnt_a);

  // first stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a <= '0;
    end else if (!run || wrap_a) begin
      cnt_a <= '0;
    end else begin
      cnt_a <= cnt_a + DIV_W'(1);
    end
  end

  // second stage advances once per first-stage wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_b <= '0;
    end else if (!run) begin
      cnt_b <= '0;
    end else if (wrap_a) begin
      cnt_b <= wrap_b ? '0 : cnt_b + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pp_shadow.sv
module pp_shadow #(
  parameter int WORD_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             ld,
  input  logic [WORD_W-1:0]      data,
  input  logic                   take,
  input  logic                   take_idx,
  output logic [1:0][WORD_W-1:0] sh,
  output logic [1:0]             full
);
  for (genvar i = 0; i < 2; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh[i]   <= '0;
        full[i] <= 1'b0;
      end else if (ld[i]) begin
        sh[i]   <= data;
        full[i] <= 1'b1;
      end else if (take && (take_idx == 1'(i))) begin
        full[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pp_shift_eng.sv
module pp_shift_eng
  import pp_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   fixed,
  input  logic [DIV_W-1:0]       div_a,
  input  logic [DIV_W-1:0]       div_b,
  input  logic [CNT_W-1:0]       nbits,
  input  logic [1:0][WORD_W-1:0] sh,
  input  logic [1:0]             full,
  input  logic                   tick,
  output logic                   run,
  output logic [DIV_W-1:0]       lat_a,
  output logic [DIV_W-1:0]       lat_b,
  output logic                   take,
  output logic                   take_idx,
  output logic                   act,
  output logic                   sdo_bit,
  output logic                   underrun
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  run_st_e           st;
  logic [WORD_W-1:0] shreg;
  logic [IDX_W-1:0]  bidx;
  logic [CNT_W-1:0]  tot;
  logic [CNT_W-1:0]  lat_n;
  logic              lat_fix;

  logic              start;
  logic              start_zero;
  logic              last_bit;
  logic              fix_end;
  logic              free_stop;
  logic              handoff;
  logic [WORD_W-1:0] nxt_word;
  logic              nxt_stale;

  assign run        = (st == ST_RUN);
  assign start      = (st == ST_IDLE) && en;
  assign start_zero = start && fixed && (nbits == '0);
  assign last_bit   = (bidx == LAST_IDX);
  assign fix_end    = lat_fix && (tot == lat_n - CNT_W'(1));
  assign free_stop  = !lat_fix && last_bit && !en;
  assign handoff    = run && tick && last_bit && !fix_end && !free_stop;
  assign take       = (start && !start_zero) || handoff;
  assign take_idx   = (st == ST_IDLE) ? 1'b0 : ~act;
  assign nxt_word   = sh[take_idx];
  assign nxt_stale  = !full[take_idx];
  assign sdo_bit    = run && shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun <= 1'b0;
    end else begin
      underrun <= take && nxt_stale;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      shreg   <= '0;
      act     <= 1'b0;
      bidx    <= '0;
      tot     <= '0;
      lat_n   <= '0;
      lat_fix <= 1'b0;
      lat_a   <= DIV_W'(1);
      lat_b   <= DIV_W'(1);
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            lat_a   <= DIV_W'(div_eff(32'(div_a)));
            lat_b   <= DIV_W'(div_eff(32'(div_b)));
            lat_n   <= nbits;
            lat_fix <= fixed;
            act     <= 1'b0;
            bidx    <= '0;
            tot     <= '0;
            if (start_zero) begin
              st <= ST_DONE;
            end else begin
              st    <= ST_RUN;
              shreg <= nxt_word;
            end
          end
        end
        ST_RUN: begin
          if (tick) begin
            tot <= tot + CNT_W'(1);
            if (fix_end) begin
              st  <= ST_DONE;
              act <= 1'b0;
            end else if (free_stop) begin
              st  <= ST_IDLE;
              act <= 1'b0;
            end else if (last_bit) begin
              shreg <= nxt_word;
              act   <= ~act;
              bidx  <= '0;
            end else begin
              shreg <= shreg >> 1;
              bidx  <= bidx + IDX_W'(1);
            end
          end
        end
        ST_DONE: begin
          if (!en) begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_shift_tx.sv
module pp_shift_tx
  import pp_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ctl_data,
  input  logic              ctl_ld0,
  input  logic              ctl_ld1,
  input  logic              ctl_en,
  input  logic              cfg_fixed,
  input  logic [DIV_W-1:0]  cfg_div_a,
  input  logic [DIV_W-1:0]  cfg_div_b,
  input  logic [CNT_W-1:0]  cfg_nbits,
  output logic              sdo,
  output logic              sclk,
  output logic              busy,
  output logic              free_buf,
  output logic              underrun
);
  localparam int PH_W = 2 * DIV_W;

  logic                   shift_tick;
  logic [PH_W-1:0]        phase;
  logic [DIV_W-1:0]       lat_a;
  logic [DIV_W-1:0]       lat_b;
  logic                   buf_take;
  logic                   take_idx;
  logic                   act;
  logic [1:0][WORD_W-1:0] sh;
  logic [1:0]             full;

  pp_div2 #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div_a (lat_a),
    .div_b (lat_b),
    .tick  (shift_tick),
    .phase (phase)
  );

  pp_shadow #(.WORD_W(WORD_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       ({ctl_ld1, ctl_ld0}),
    .data     (ctl_data),
    .take     (buf_take),
    .take_idx (take_idx),
    .sh       (sh),
    .full     (full)
  );

  pp_shift_eng #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_en),
    .fixed    (cfg_fixed),
    .div_a    (cfg_div_a),
    .div_b    (cfg_div_b),
    .nbits    (cfg_nbits),
    .sh       (sh),
    .full     (full),
    .tick     (shift_tick),
    .run      (busy),
    .lat_a    (lat_a),
    .lat_b    (lat_b),
    .take     (buf_take),
    .take_idx (take_idx),
    .act      (act),
    .sdo_bit  (sdo),
    .underrun (underrun)
  );

  assign sclk     = busy && sclk_level(32'(phase), 32'(lat_a), 32'(lat_b));
  assign free_buf = ~act;
endmodule

// File: rtl/pp_shift_chk.sv
module pp_shift_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sdo,
  input logic sclk,
  input logic free_buf,
  input logic underrun,
  input logic tick,
  input logic take
);
  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && !$past(tick) |-> busy && $stable(sdo));

  // R4
  sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(tick) || $rose(busy));

  // R6
  free_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(free_buf) |-> $past(busy));

  // R7
  underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(take) && busy);

  // R8
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));
endmodule

bind pp_shift_tx pp_shift_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .sdo      (sdo),
  .sclk     (sclk),
  .free_buf (free_buf),
  .underrun (underrun),
  .tick     (shift_tick),
  .take     (buf_take)
);

// File: tb/sim_pp_shift_tx.sv
module sim_pp_shift_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctl_data = '0;
  logic        ctl_ld0 = 1'b0;
  logic        ctl_ld1 = 1'b0;
  logic        ctl_en = 1'b0;
  logic        cfg_fixed = 1'b0;
  logic [3:0]  cfg_div_a = '0;
  logic [3:0]  cfg_div_b = '0;
  logic [7:0]  cfg_nbits = '0;
  logic        sdo, sclk, busy, free_buf, underrun;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pp_shift_tx u0 (
    .clk(clk), .rst_n(rst_n), .ctl_data(ctl_data), .ctl_ld0(ctl_ld0), .ctl_ld1(ctl_ld1),
    .ctl_en(ctl_en), .cfg_fixed(cfg_fixed), .cfg_div_a(cfg_div_a), .cfg_div_b(cfg_div_b),
    .cfg_nbits(cfg_nbits), .sdo(sdo), .sclk(sclk), .busy(busy), .free_buf(free_buf),
    .underrun(underrun)
  );

  function automatic int eff(input int v);
    return (v <= 1) ? 1 : v;
  endfunction

  task automatic chk(input logic act_v, input logic exp_v, input string tag, input string what);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b @%0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  // loads both buffers, starts a run, then checks every cycle against the arithmetic model
  task automatic run_case(input int a, input int b, input logic fx, input int n,
                          input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                          input int reload_c, input int en_lo_c, input int glitch_c,
                          input int nb, input logic [2:0] umask, input int ncyc,
                          input string tag);
    int p;
    logic [47:0] stream;
    p = eff(a) * eff(b);
    stream = {w2, w1, w0};
    cfg_div_a = 4'(a); cfg_div_b = 4'(b); cfg_fixed = fx; cfg_nbits = 8'(n);
    ctl_data = w0; ctl_ld0 = 1'b1;
    @(negedge clk);
    ctl_ld0 = 1'b0; ctl_data = w1; ctl_ld1 = 1'b1;
    @(negedge clk);
    ctl_ld1 = 1'b0; ctl_data = w2; ctl_en = 1'b1;
    @(negedge clk);
    for (int c = 0; c < ncyc; c++) begin
      logic eb, es, ek, ef, eu;
      int k;
      k  = c / p;
      eb = (c < nb * p);
      es = eb ? stream[k] : 1'b0;
      ek = eb && ((c % p) < (p + 1) / 2);
      ef = eb ? ~((k / 16) % 2 == 1) : 1'b1;
      eu = eb && (c % (16 * p) == 0) && umask[k / 16];
      chk(busy, eb, (fx ? "R9" : "R8"), "busy");
      chk(sdo, es, tag, "sdo");
      chk(sclk, ek, "R4", "sclk");
      chk(free_buf, ef, "R6", "free_buf");
      chk(underrun, eu, "R7", "underrun");
      ctl_ld0 = (c == reload_c);
      ctl_en  = !((c >= en_lo_c) || (c == glitch_c));
      @(negedge clk);
    end
    ctl_en = 1'b0; ctl_ld0 = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, 1'b0, "R8", "busy after case");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(sdo, 1'b0, "R1", "sdo");
    chk(sclk, 1'b0, "R1", "sclk");
    chk(busy, 1'b0, "R1", "busy");
    chk(underrun, 1'b0, "R1", "underrun");
    chk(free_buf, 1'b1, "R1", "free_buf");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6: divider sweep, free-running, active buffer reloaded mid-word,
    // enable glitch mid-buffer ignored, stop after the third word
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        int p;
        p = eff(a) * eff(b);
        run_case(a, b, 1'b0, 0,
                 16'hA5C3 ^ 16'(a * 16'h1111), 16'h3C96 ^ 16'(b * 16'h0F0F),
                 16'h5E21 + 16'(a * 7 + b),
                 2, 32 * p + 1, 5, 48, 3'b000, 48 * p + 4, "R2 R3 R5 R6");
      end
    end

    // R7: third word not reloaded, stale buffer 0 goes out again
    run_case(1, 2, 1'b0, 0, 16'hC0DE, 16'h1B2D, 16'hC0DE,
             -1, 65, -1, 48, 3'b100, 100, "R7");

    // R8: enable dropped early, first buffer still completes
    run_case(3, 1, 1'b0, 0, 16'h8001, 16'hFFFF, 16'h0000,
             -1, 3, -1, 16, 3'b000, 60, "R8");

    // R9: fixed counts, including zero, a swap boundary and an early enable drop
    run_case(2, 1, 1'b1, 0, 16'h1234, 16'h5678, 16'h9ABC, 2, 1000, -1, 0, 3'b000, 20, "R9");
    run_case(2, 1, 1'b1, 1, 16'h0001, 16'h5678, 16'h9ABC, 2, 1000, -1, 1, 3'b000, 22, "R9");
    run_case(2, 1, 1'b1, 5, 16'h00F5, 16'h5678, 16'h9ABC, 2, 1000, -1, 5, 3'b000, 30, "R9");
    run_case(2, 1, 1'b1, 16, 16'hBEEF, 16'h5678, 16'h9ABC, 2, 1000, -1, 16, 3'b000, 52, "R9");
    run_case(2, 1, 1'b1, 33, 16'h7E81, 16'h1357, 16'hFFFF, 2, 20, -1, 33, 3'b000, 86, "R9");
    run_case(2, 1, 1'b1, 17, 16'hAAAA, 16'h0003, 16'h9ABC, 2, 1000, -1, 17, 3'b000, 54, "R9");

    // R10: previous run ended in buffer 1, this one must open with buffer 0
    run_case(0, 0, 1'b0, 0, 16'h6D4B, 16'hE817, 16'h2F0C, 2, 33, -1, 48, 3'b000, 52, "R10");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule